// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block takes one fast clock and derives two divided clock banks, A and B. Each bank picks its own even divide ratio from a small set. The block then works out where the rising edges of the two banks line up again. Before each such shared rising edge it drives an active-low strobe, `sync_n`, so that downstream logic knows the shared edge is coming. This matters most when neither bank frequency is an integer multiple of the other.

The strobe is timed against the faster bank. It goes low on a falling edge of the faster bank and stays low for exactly one period of that bank. It is therefore low and stable at the faster bank's rising edge one period before the shared edge. It is high again at the shared edge itself.

The strobe position comes from a count that runs modulo the least common multiple of the two ratios, not from the divided clocks. Bank B can be inverted, which shifts it by 180 degrees. The inversion changes only the bank B output pin and has no effect on the strobe timing.

Ratio selects are captured only while reset is high. A small control machine has three states:
- HOLD: entered on reset. The selects are captured here.
- RUN_SYNC: entered from HOLD when the captured ratios differ. The strobe is enabled.
- RUN_FREE: entered from HOLD when the captured ratios are equal. The strobe is suppressed.

Each run state keeps itself until the next reset returns the machine to HOLD.

Top module: `cesync_gen`

## Requirements
- R1: Each bank divides by a ratio chosen by its 2-bit select: code 0 gives 4, code 1 gives 6, code 2 gives 8, code 3 gives 12. A non-inverted bank is high for the first half of each period. Counting fast-clock edges from k=0 at the first edge with reset low, a bank with ratio r is high after edge k when (k mod r) < r/2.
- R2: Both banks produce a rising edge on the first fast-clock edge after reset is released.
- R3: Reset is synchronous and active high. After any edge with reset high, `clk_a` and `clk_b` are low and `sync_n` is high.
- R4: `sel_a` and `sel_b` are captured on edges with reset high. A change while running has no effect until the next reset.
- R5: Each low pulse of `sync_n` lasts exactly F fast-clock cycles, where F is the smaller of the two ratios.
- R6: With different ratios, let L be their least common multiple. Then `sync_n` is low after edge k exactly when ((k + 3F/2) mod L) < F. As a result it is low at the faster bank's rising edge before each shared rising edge (k mod L = 0) and high at the shared edge.
- R7: `sync_n` changes only on an edge where the faster bank (non-inverted level) falls.
- R8: With equal ratios, `sync_n` stays high.
- R9: With `inv_b` high, `clk_b` is the bank B level inverted, using `inv_b` as sampled at the same edge. The strobe timing does not change.
- R10: When one ratio is an integer multiple of the other (for example 4 and 8), the strobe still follows R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset; selects are captured while it is high |
| sel_a | input | 2 | Ratio select for bank A |
| sel_b | input | 2 | Ratio select for bank B |
| inv_b | input | 1 | Invert (180-degree shift) of bank B |
| clk_a | output | 1 | Divided clock, bank A |
| clk_b | output | 1 | Divided clock, bank B, optionally inverted |
| sync_n | output | 1 | Active-low strobe ahead of the shared rising edge |

## Verification
The hardest case to reach is a coincidence point that comes around only once per least-common-multiple window. For ratios 8 and 12 this window is 24 cycles, and the strobe must also be placed correctly in the same run in which the faster bank switches from A to B. The stimulus sweeps ratio pairs in both orders, including the pair with the longest common period, an integer-multiple pair and an equal pair. Each pair runs for several whole common periods. Mid-run, the selects are moved and the inversion is toggled, to show that only a reset brings in new ratios and that the inversion never moves the strobe.

// File: rtl/cesync_pkg.sv
package cesync_pkg;

    localparam int SEL_W = 2;
    localparam int NSEL  = 1 << SEL_W;

    typedef enum logic [1:0] {
        ST_HOLD     = 2'd0,
        ST_RUN_SYNC = 2'd1,
        ST_RUN_FREE = 2'd2
    } mode_e;

    // Smallest common multiple of two positive ratios (elaboration time only).
    function automatic int lcm_of(input int a, input int b);
        int res;
        res = a * b;
        for (int m = b; m >= 1; m--) begin
            if (((a * m) % b) == 0) res = a * m;
        end
        return res;
    endfunction

endpackage

// File: rtl/cesync_ctrl.sv
module cesync_ctrl
    import cesync_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV0  = 4,
    parameter int DIV1  = 6,
    parameter int DIV2  = 8,
    parameter int DIV3  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic [CNT_W-1:0] ratio_a,
    output logic [CNT_W-1:0] ratio_b,
    output logic [CNT_W-1:0] ratio_fast,
    output logic [CNT_W-1:0] period_lcm,
    output logic             strobe_en
);

    localparam int DIVS [NSEL] = '{DIV0, DIV1, DIV2, DIV3};

    logic [CNT_W-1:0] div_lut [NSEL];
    logic [CNT_W-1:0] lcm_tab [NSEL][NSEL];

    genvar gi, gj;
    generate
        for (gi = 0; gi < NSEL; gi++) begin : g_row
            assign div_lut[gi] = CNT_W'(DIVS[gi]);
            for (gj = 0; gj < NSEL; gj++) begin : g_col
                assign lcm_tab[gi][gj] = CNT_W'(lcm_of(DIVS[gi], DIVS[gj]));
            end
        end
    endgenerate

    mode_e state, state_nxt;

    // Ratio capture: only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_a    <= div_lut[sel_a];
            ratio_b    <= div_lut[sel_b];
            ratio_fast <= (div_lut[sel_a] <= div_lut[sel_b]) ? div_lut[sel_a] : div_lut[sel_b];
            period_lcm <= lcm_tab[sel_a][sel_b];
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:     state_nxt = (ratio_a == ratio_b) ? ST_RUN_FREE : ST_RUN_SYNC;
            ST_RUN_SYNC: state_nxt = ST_RUN_SYNC;
            ST_RUN_FREE: state_nxt = ST_RUN_FREE;
            default:     state_nxt = ST_HOLD;
        endcase
    end

    // Outputs of the machine.
    always_comb begin
        strobe_en = 1'b0;
        unique case (state)
            ST_HOLD:     strobe_en = 1'b0;
            ST_RUN_SYNC: strobe_en = 1'b1;
            ST_RUN_FREE: strobe_en = 1'b0;
            default:     strobe_en = 1'b0;
        endcase
    end

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(ratio_a) && $stable(ratio_b) && $stable(period_lcm));

    // R8
    free_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_a == ratio_b) |-> !strobe_en);

endmodule

// File: rtl/cesync_bank_div.sv
module cesync_bank_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ratio,
    input  logic             invert,
    output logic             level,
    output logic             clk_out
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] half_len;
    logic             first_half;

    assign half_len   = ratio >> 1;
    assign first_half = (phase < half_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            level   <= 1'b0;
            clk_out <= 1'b0;
        end else begin
            phase   <= (phase == ratio - ONE) ? '0 : phase + ONE;
            level   <= first_half;
            clk_out <= first_half ^ invert;
        end
    end

    // Checker: length of each high phase of the bank level.
    logic [CNT_W-1:0] high_len;
    always_ff @(posedge clk) begin
        if (rst)        high_len <= '0;
        else if (level) high_len <= high_len + ONE;
        else            high_len <= '0;
    end

    // R1
    half_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> (high_len == half_len));

endmodule

// File: rtl/cesync_strobe.sv
module cesync_strobe #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] period_lcm,
    input  logic [CNT_W-1:0] ratio_fast,
    output logic             sync_n
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] tick;
    logic [CNT_W-1:0] lead;
    logic [CNT_W:0]   ahead;
    logic             in_window;

    // Window opens 1.5 fast periods before the shared edge.
    assign lead = ratio_fast + (ratio_fast >> 1);

    always_comb begin
        ahead = {1'b0, tick} + {1'b0, lead};
        if (ahead >= {1'b0, period_lcm}) ahead = ahead - {1'b0, period_lcm};
        in_window = (ahead < {1'b0, ratio_fast});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick   <= '0;
            sync_n <= 1'b1;
        end else begin
            tick   <= (tick == period_lcm - ONE) ? '0 : tick + ONE;
            sync_n <= !(enable && in_window);
        end
    end

    // Checker: length of each low pulse.
    logic [CNT_W-1:0] low_len;
    always_ff @(posedge clk) begin
        if (rst)         low_len <= '0;
        else if (!sync_n) low_len <= low_len + ONE;
        else             low_len <= '0;
    end

    // R5
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (low_len == ratio_fast));

endmodule

// File: rtl/cesync_gen.sv
module cesync_gen
    import cesync_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV0  = 4,
    parameter int DIV1  = 6,
    parameter int DIV2  = 8,
    parameter int DIV3  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic             inv_b,
    output logic             clk_a,
    output logic             clk_b,
    output logic             sync_n
);

    logic [CNT_W-1:0] ratio_a, ratio_b, ratio_fast, period_lcm;
    logic             strobe_en;

    cesync_ctrl #(
        .CNT_W(CNT_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .ratio_a    (ratio_a),
        .ratio_b    (ratio_b),
        .ratio_fast (ratio_fast),
        .period_lcm (period_lcm),
        .strobe_en  (strobe_en)
    );

    logic [CNT_W-1:0] bank_ratio [2];
    logic             bank_inv   [2];
    logic             bank_lvl   [2];
    logic             bank_out   [2];

    assign bank_ratio[0] = ratio_a;
    assign bank_ratio[1] = ratio_b;
    assign bank_inv[0]   = 1'b0;
    assign bank_inv[1]   = inv_b;

    genvar gb;
    generate
        for (gb = 0; gb < 2; gb++) begin : g_bank
            cesync_bank_div #(.CNT_W(CNT_W)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .ratio   (bank_ratio[gb]),
                .invert  (bank_inv[gb]),
                .level   (bank_lvl[gb]),
                .clk_out (bank_out[gb])
            );
        end
    endgenerate

    assign clk_a = bank_out[0];
    assign clk_b = bank_out[1];

    cesync_strobe #(.CNT_W(CNT_W)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .enable     (strobe_en),
        .period_lcm (period_lcm),
        .ratio_fast (ratio_fast),
        .sync_n     (sync_n)
    );

    logic fast_lvl;
    assign fast_lvl = (ratio_a <= ratio_b) ? bank_lvl[0] : bank_lvl[1];

    // R3
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!clk_a && !clk_b && sync_n));

    // R7
    strobe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n != $past(sync_n)) |-> $fell(fast_lvl));

    // R6
    coincide_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(bank_lvl[0]) && $rose(bank_lvl[1])) |-> sync_n);

    // R9
    invert_b_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (clk_b == (bank_lvl[1] ^ $past(inv_b))));

endmodule

// File: tb/cesync_gen_bench.sv
`timescale 1ns/1ps
module cesync_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel_a = 2'd0;
    logic [1:0] sel_b = 2'd0;
    logic       inv_b = 1'b0;
    logic       clk_a, clk_b, sync_n;

    always #2.5 clk = ~clk;

    cesync_gen u_cesync_gen (
        .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
        .inv_b(inv_b), .clk_a(clk_a), .clk_b(clk_b), .sync_n(sync_n)
    );

    int  checks = 0;
    int  fails  = 0;
    int  kk     = -1;
    int  ra_m   = 4;
    int  rb_m   = 4;
    logic inv_m = 1'b0;
    bit  done   = 1'b0;
    bit  moved  = 1'b0;

    function automatic int div_of(input logic [1:0] s);
        case (s)
            2'd0:    return 4;
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int lcm_i(input int a, input int b);
        int m;
        m = a;
        while ((m % b) != 0) m += a;
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d ra=%0d rb=%0d)",
                     tag, act, exp, kk, ra_m, rb_m);
        end
    endtask

    // Reference model state: edge index and captured ratios.
    always @(posedge clk) begin
        if (rst) begin
            kk   <= -1;
            ra_m <= div_of(sel_a);
            rb_m <= div_of(sel_b);
        end else begin
            kk <= kk + 1;
        end
        inv_m <= inv_b;
    end

    int   rf, lm, low_run;
    logic ea, eb, es, fast_obs, a_obs, b_obs;
    logic prev_sync, prev_fast, prev_a, prev_b, rise_sync;
    string tag_c, tag_s;

    always @(negedge clk) begin
        if (!done) begin
            if (kk < 0) begin
                // R3 reset state
                chk(!clk_a && !clk_b && sync_n, "R3", {clk_a, clk_b, sync_n}, 1);
                low_run = 0; prev_sync = 1'b1; prev_fast = 1'b0;
                prev_a = 1'b0; prev_b = 1'b0; rise_sync = 1'b1;
            end else begin
                rf = (ra_m <= rb_m) ? ra_m : rb_m;
                lm = lcm_i(ra_m, rb_m);
                ea = (kk % ra_m) < (ra_m / 2);
                eb = ((kk % rb_m) < (rb_m / 2)) ^ inv_m;
                es = !((ra_m != rb_m) && (((kk + rf + rf / 2) % lm) < rf));
                tag_c = moved ? "R4" : "R1";
                if (ra_m == rb_m)                          tag_s = "R8";
                else if (lm == ((ra_m > rb_m) ? ra_m : rb_m)) tag_s = "R10";
                else                                       tag_s = moved ? "R4" : "R6";
                chk(clk_a == ea, tag_c, clk_a, ea);
                chk(clk_b == eb, inv_m ? "R9" : tag_c, clk_b, eb);
                chk(sync_n == es, tag_s, sync_n, es);
                a_obs    = clk_a;
                b_obs    = clk_b ^ inv_m;
                fast_obs = (ra_m <= rb_m) ? a_obs : b_obs;
                if (kk == 0) chk(a_obs && b_obs, "R2", {a_obs, b_obs}, 3);
                if (kk > 0 && sync_n != prev_sync)
                    chk(prev_fast && !fast_obs, "R7", {prev_fast, fast_obs}, 2);
                if (kk > 0 && sync_n && !prev_sync)
                    chk(low_run == rf, "R5", low_run, rf);
                if (kk > 0 && a_obs && !prev_a && b_obs && !prev_b)
                    chk(sync_n && (ra_m == rb_m || !rise_sync), "R6",
                        {sync_n, rise_sync}, 2);
                if (fast_obs && !prev_fast) rise_sync = sync_n;
                low_run   = sync_n ? 0 : low_run + 1;
                prev_sync = sync_n;
                prev_fast = fast_obs;
                prev_a    = a_obs;
                prev_b    = b_obs;
            end
        end
    end

    task automatic run_case(input logic [1:0] sa, input logic [1:0] sb,
                            input logic inv, input int cycles);
        @(negedge clk);
        moved = 1'b0;
        rst   = 1'b1;
        sel_a = sa;
        sel_b = sb;
        inv_b = inv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        run_case(2'd0, 2'd1, 1'b0, 60);   // 4 and 6
        run_case(2'd1, 2'd0, 1'b1, 60);   // 6 and 4, B inverted
        run_case(2'd2, 2'd3, 1'b0, 96);   // 8 and 12, longest window
        run_case(2'd3, 2'd2, 1'b1, 96);   // 12 and 8
        run_case(2'd0, 2'd2, 1'b0, 40);   // R10: 4 and 8
        run_case(2'd1, 2'd1, 1'b0, 36);   // R8: equal
        run_case(2'd1, 2'd2, 1'b0, 72);   // 6 and 8
        // R4 and R9: move selects and toggle inversion while running.
        run_case(2'd3, 2'd0, 1'b0, 20);
        moved = 1'b1;
        sel_a = 2'd0;
        sel_b = 2'd1;
        inv_b = 1'b1;
        repeat (30) @(negedge clk);
        inv_b = 1'b0;
        repeat (30) @(negedge clk);
        run_case(2'd0, 2'd1, 1'b0, 40);   // new selects only after reset
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule